// File: doc/BRIEF.md
# Linked-List DMA Channel

This block is one channel of a memory-to-memory and peripheral DMA engine. Software points it at a chain of descriptors in memory and sets the run bit. The channel then reads each descriptor and copies the requested number of bytes from a source address to a target address, one element at a time. After each descriptor it either follows the link to the next one or halts. Each descriptor is four 32-bit words: the link word, then the source address, then the target address, then the command word.

The command word selects the element width, the burst size and whether each address advances. It also chooses whether bursts wait for a peripheral request line and which interrupt flags the descriptor raises. A direct mode skips the descriptor reads and runs a single transfer from values written into the channel's own source, target and command registers. All memory traffic uses a simple request/acknowledge port with one access outstanding at a time.

Top module: `chain_dma_chan`

## Requirements
- R1: After reset the control/status register (address 0) reads 0x0000_0008: only the stopped bit (bit 3) is set. `irq` is low.
- R2: Writing run (bit 31 of address 0) while stopped starts a chain at the address held in the link register (address 1). The channel reads the four words at that address as link, source, target and command. After a descriptor completes, it follows link bits 31:4 as the next 16-byte-aligned descriptor address. It halts after a descriptor whose link bit 0 is set; it then clears run, sets stopped, and the link register reads the last link word.
- R3: Command bits 15:14 set the element width: 1 means one byte, 2 means two bytes, 3 or 0 means four bytes. Command bits 12:0 give the byte count, and the target receives the source bytes in order. The final element is shortened when the count is not a multiple of the width, and a count of zero moves no data.
- R4: Command bit 31 advances the source address by each element's size, and bit 30 does the same for the target address. A cleared bit keeps that address fixed. Addresses 2 and 3 read the current source and target addresses, and bits 12:0 of address 4 read the bytes still to move.
- R5: When command bit 29 or bit 28 is set, each burst waits for `dreq` to be high. Command bits 17:16 set the burst size: 1 means 8 bytes, 2 means 16, 3 means 32, and 0 means one element. Status bit 8 shows `dreq` after synchronisation.
- R6: Status bit 2 (end) is set when a descriptor completes with command bit 21 set. Status bit 1 (start) is set when a descriptor is loaded with command bit 22 set.
- R7: Writing a one to status bits 2, 1 or 0 clears that flag. Writing a zero leaves the flag unchanged.
- R8: An error response on any memory access sets status bit 0, clears run and sets stopped.
- R9: Clearing run stops the channel at the next burst or descriptor boundary, and stopped then reads 1.
- R10: With bit 30 of address 0 set, run starts a single transfer from the values in addresses 2, 3 and 4. The channel issues no descriptor read and stops afterwards.
- R11: Writes to addresses 1 to 4 are ignored while the channel is not stopped.
- R12: `irq` is the OR of the end, start and bus-error flags, plus the stopped bit when status bit 29 is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register select: 0 control/status, 1 link, 2 source, 3 target, 4 command |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data of the selected register |
| mem_req | output | 1 | Memory access request, held until acknowledged |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 32 | Byte address of the access |
| mem_nbytes | output | 3 | Bytes in the access (1 to 4), right-aligned in the data |
| mem_wdata | output | 32 | Write data |
| mem_ack | input | 1 | Access complete |
| mem_err | input | 1 | Error response, valid with `mem_ack` |
| mem_rdata | input | 32 | Read data, valid with `mem_ack` |
| dreq | input | 1 | Peripheral request for flow-controlled bursts |
| irq | output | 1 | Channel interrupt |

## Verification
A wrong sequencer state shows up at the memory port first. A bad fetch counter puts link, address or command words into the wrong registers, so the next read goes to a wrong address within about two cycles. The target bytes then differ from the source pattern as soon as that descriptor completes.

Broken flag logic shows on `irq` and in the status read on the cycle after the event. A bad stop condition shows in two ways: a descriptor that should have been skipped writes into a target region, or the stopped bit never rises and the bench poll times out.

// File: rtl/chan_dma_pkg.sv
package chan_dma_pkg;

   // register select codes
   localparam logic [2:0] RA_CSR  = 3'd0;
   localparam logic [2:0] RA_LINK = 3'd1;
   localparam logic [2:0] RA_SRC  = 3'd2;
   localparam logic [2:0] RA_TGT  = 3'd3;
   localparam logic [2:0] RA_CMD  = 3'd4;

   // command word fields
   localparam int C_SRC_INC  = 31;
   localparam int C_TGT_INC  = 30;
   localparam int C_PACE_SRC = 29;
   localparam int C_PACE_TGT = 28;
   localparam int C_START_IE = 22;
   localparam int C_END_IE   = 21;
   localparam int C_BURST_LO = 16;
   localparam int C_WIDTH_LO = 14;
   localparam int LEN_W      = 13;

   // control/status fields
   localparam int S_RUN     = 31;
   localparam int S_DIRECT  = 30;
   localparam int S_STOP_IE = 29;
   localparam int S_REQ     = 8;
   localparam int S_STOPPED = 3;
   localparam int S_END     = 2;
   localparam int S_START   = 1;
   localparam int S_BERR    = 0;

   typedef enum logic [2:0] {
      SQ_IDLE,
      SQ_FETCH,
      SQ_GATE,
      SQ_READ,
      SQ_WRITE,
      SQ_CLOSE
   } seq_state_t;

   function automatic logic [2:0] elem_bytes(input logic [1:0] code);
      case (code)
         2'd1:    elem_bytes = 3'd1;
         2'd2:    elem_bytes = 3'd2;
         default: elem_bytes = 3'd4;
      endcase
   endfunction

   function automatic logic [5:0] burst_len(input logic [1:0] code, input logic [2:0] wb);
      case (code)
         2'd1:    burst_len = 6'd8;
         2'd2:    burst_len = 6'd16;
         2'd3:    burst_len = 6'd32;
         default: burst_len = {3'b000, wb};
      endcase
   endfunction

endpackage

// File: rtl/chan_dma_sync.sv
module chan_dma_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   generate
      if (STAGES == 0) begin : g_pass
         assign q = d;
      end else begin : g_chain
         logic [STAGES-1:0] sh;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               sh <= '0;
            end else begin
               sh[0] <= d;
               for (int i = 1; i < STAGES; i++) sh[i] <= sh[i-1];
            end
         end
         assign q = sh[STAGES-1];
      end
   endgenerate
endmodule

// File: rtl/chan_dma_regs.sv
module chan_dma_regs
   import chan_dma_pkg::*;
(
   input  logic        clk,
   input  logic        rst_n,
   input  logic        csr_we,
   input  logic [5:0]  csr_bits,   // {run, direct, stop_ie, end, start, berr}
   input  logic        clr_run,
   input  logic        set_end,
   input  logic        set_start,
   input  logic        set_err,
   input  logic        stopped,
   input  logic        dreq_s,
   output logic        run,
   output logic        direct,
   output logic        stop_ie,
   output logic        flag_end,
   output logic        flag_start,
   output logic        flag_err,
   output logic        irq,
   output logic [31:0] csr_value
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run        <= 1'b0;
         direct     <= 1'b0;
         stop_ie    <= 1'b0;
         flag_end   <= 1'b0;
         flag_start <= 1'b0;
         flag_err   <= 1'b0;
      end else begin
         if (csr_we) begin
            run     <= csr_bits[5];
            direct  <= csr_bits[4];
            stop_ie <= csr_bits[3];
         end else if (clr_run) begin
            run <= 1'b0;
         end
         flag_end   <= set_end   | (flag_end   & ~(csr_we & csr_bits[2]));
         flag_start <= set_start | (flag_start & ~(csr_we & csr_bits[1]));
         flag_err   <= set_err   | (flag_err   & ~(csr_we & csr_bits[0]));
      end
   end

   assign irq = flag_end | flag_start | flag_err | (stopped & stop_ie);

   always_comb begin
      csr_value            = '0;
      csr_value[S_RUN]     = run;
      csr_value[S_DIRECT]  = direct;
      csr_value[S_STOP_IE] = stop_ie;
      csr_value[S_REQ]     = dreq_s;
      csr_value[S_STOPPED] = stopped;
      csr_value[S_END]     = flag_end;
      csr_value[S_START]   = flag_start;
      csr_value[S_BERR]    = flag_err;
   end
endmodule

// File: rtl/chan_dma_seq.sv
module chan_dma_seq
   import chan_dma_pkg::*;
(
   input  logic        clk,
   input  logic        rst_n,
   input  logic        run,
   input  logic        direct,
   input  logic        dreq_s,
   input  logic        wr_en,
   input  logic [2:0]  wr_addr,
   input  logic [31:0] wr_data,
   output logic        mem_req,
   output logic        mem_we,
   output logic [31:0] mem_addr,
   output logic [2:0]  mem_nbytes,
   output logic [31:0] mem_wdata,
   input  logic        mem_ack,
   input  logic        mem_err,
   input  logic [31:0] mem_rdata,
   output logic        stopped,
   output logic        clr_run,
   output logic        set_end,
   output logic        set_start,
   output logic        set_err,
   output logic [31:0] link_q,
   output logic [31:0] src_q,
   output logic [31:0] tgt_q,
   output logic [31:0] cmd_word
);
   localparam int REM_PAD = LEN_W - 3;

   seq_state_t       state;
   logic [31:4]      desc_q;
   logic [1:0]       widx;
   logic [31:0]      cmd_q;
   logic [LEN_W-1:0] rem_q;
   logic [5:0]       bleft_q;
   logic [31:0]      data_q;

   logic [2:0]       wb;
   logic [2:0]       elem;
   logic [5:0]       bleft_n;
   logic             paced;
   logic             acc;
   logic             last_elem;

   assign wb        = elem_bytes(cmd_q[C_WIDTH_LO +: 2]);
   assign elem      = (rem_q < {{REM_PAD{1'b0}}, wb}) ? rem_q[2:0] : wb;
   assign bleft_n   = (bleft_q > {3'b000, elem}) ? bleft_q - {3'b000, elem} : 6'd0;
   assign paced     = cmd_q[C_PACE_SRC] | cmd_q[C_PACE_TGT];
   assign last_elem = (rem_q == {{REM_PAD{1'b0}}, elem});

   assign mem_req    = (state == SQ_FETCH) || (state == SQ_READ) || (state == SQ_WRITE);
   assign mem_we     = (state == SQ_WRITE);
   assign mem_addr   = (state == SQ_FETCH) ? {desc_q, widx, 2'b00} :
                       (state == SQ_READ)  ? src_q : tgt_q;
   assign mem_nbytes = (state == SQ_FETCH) ? 3'd4 : elem;
   assign mem_wdata  = data_q;
   assign acc        = mem_req & mem_ack;

   assign stopped   = (state == SQ_IDLE);
   assign set_err   = acc & mem_err;
   assign set_end   = (state == SQ_CLOSE) & cmd_q[C_END_IE];
   assign set_start = ((state == SQ_IDLE) & run & direct & cmd_q[C_START_IE]) |
                      ((state == SQ_FETCH) & acc & ~mem_err & (widx == 2'd3) &
                       mem_rdata[C_START_IE]);
   assign clr_run   = set_err |
                      ((state == SQ_CLOSE) & run & (direct | link_q[0]));
   assign cmd_word  = {cmd_q[31:LEN_W], rem_q};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state   <= SQ_IDLE;
         desc_q  <= '0;
         widx    <= '0;
         link_q  <= '0;
         src_q   <= '0;
         tgt_q   <= '0;
         cmd_q   <= '0;
         rem_q   <= '0;
         bleft_q <= '0;
         data_q  <= '0;
      end else begin
         case (state)
            SQ_IDLE: begin
               if (wr_en) begin
                  case (wr_addr)
                     RA_LINK: link_q <= wr_data;
                     RA_SRC:  src_q  <= wr_data;
                     RA_TGT:  tgt_q  <= wr_data;
                     RA_CMD: begin
                        cmd_q <= wr_data;
                        rem_q <= wr_data[LEN_W-1:0];
                     end
                     default: ;
                  endcase
               end else if (run) begin
                  if (direct) begin
                     state <= SQ_GATE;
                  end else begin
                     desc_q <= link_q[31:4];
                     widx   <= 2'd0;
                     state  <= SQ_FETCH;
                  end
               end
            end
            SQ_FETCH: begin
               if (acc) begin
                  if (mem_err) begin
                     state <= SQ_IDLE;
                  end else begin
                     case (widx)
                        2'd0: link_q <= mem_rdata;
                        2'd1: src_q  <= mem_rdata;
                        2'd2: tgt_q  <= mem_rdata;
                        default: begin
                           cmd_q <= mem_rdata;
                           rem_q <= mem_rdata[LEN_W-1:0];
                        end
                     endcase
                     widx <= widx + 2'd1;
                     if (widx == 2'd3) state <= SQ_GATE;
                  end
               end
            end
            SQ_GATE: begin
               if (!run) begin
                  state <= SQ_IDLE;
               end else if (rem_q == '0) begin
                  state <= SQ_CLOSE;
               end else if (!paced || dreq_s) begin
                  bleft_q <= burst_len(cmd_q[C_BURST_LO +: 2], wb);
                  state   <= SQ_READ;
               end
            end
            SQ_READ: begin
               if (acc) begin
                  if (mem_err) begin
                     state <= SQ_IDLE;
                  end else begin
                     data_q <= mem_rdata;
                     state  <= SQ_WRITE;
                  end
               end
            end
            SQ_WRITE: begin
               if (acc) begin
                  if (mem_err) begin
                     state <= SQ_IDLE;
                  end else begin
                     if (cmd_q[C_SRC_INC]) src_q <= src_q + {29'd0, elem};
                     if (cmd_q[C_TGT_INC]) tgt_q <= tgt_q + {29'd0, elem};
                     rem_q   <= rem_q - {{REM_PAD{1'b0}}, elem};
                     bleft_q <= bleft_n;
                     if (last_elem)           state <= SQ_CLOSE;
                     else if (bleft_n == 6'd0) state <= SQ_GATE;
                     else                      state <= SQ_READ;
                  end
               end
            end
            SQ_CLOSE: begin
               if (!run || direct || link_q[0]) begin
                  state <= SQ_IDLE;
               end else begin
                  desc_q <= link_q[31:4];
                  widx   <= 2'd0;
                  state  <= SQ_FETCH;
               end
            end
            default: state <= SQ_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/chain_dma_chan.sv
module chain_dma_chan
   import chan_dma_pkg::*;
#(
   parameter int SYNC_STAGES = 2
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        reg_we,
   input  logic [2:0]  reg_addr,
   input  logic [31:0] reg_wdata,
   output logic [31:0] reg_rdata,
   output logic        mem_req,
   output logic        mem_we,
   output logic [31:0] mem_addr,
   output logic [2:0]  mem_nbytes,
   output logic [31:0] mem_wdata,
   input  logic        mem_ack,
   input  logic        mem_err,
   input  logic [31:0] mem_rdata,
   input  logic        dreq,
   output logic        irq
);
   generate
      if (SYNC_STAGES < 0 || SYNC_STAGES > 4) begin : g_bad_sync
         $error("SYNC_STAGES must lie in 0..4");
      end
   endgenerate

   logic        dreq_s;
   logic        run, direct, stop_ie;
   logic        flag_end, flag_start, flag_err;
   logic        stopped, clr_run, set_end, set_start, set_err;
   logic        csr_we;
   logic [31:0] csr_value, link_q, src_q, tgt_q, cmd_word;

   assign csr_we = reg_we & (reg_addr == RA_CSR);

   chan_dma_sync #(.STAGES(SYNC_STAGES)) i_sync (
      .clk (clk), .rst_n (rst_n), .d (dreq), .q (dreq_s)
   );

   chan_dma_regs i_regs (
      .clk        (clk),
      .rst_n      (rst_n),
      .csr_we     (csr_we),
      .csr_bits   ({reg_wdata[S_RUN], reg_wdata[S_DIRECT], reg_wdata[S_STOP_IE],
                    reg_wdata[S_END], reg_wdata[S_START], reg_wdata[S_BERR]}),
      .clr_run    (clr_run),
      .set_end    (set_end),
      .set_start  (set_start),
      .set_err    (set_err),
      .stopped    (stopped),
      .dreq_s     (dreq_s),
      .run        (run),
      .direct     (direct),
      .stop_ie    (stop_ie),
      .flag_end   (flag_end),
      .flag_start (flag_start),
      .flag_err   (flag_err),
      .irq        (irq),
      .csr_value  (csr_value)
   );

   chan_dma_seq i_seq (
      .clk        (clk),
      .rst_n      (rst_n),
      .run        (run),
      .direct     (direct),
      .dreq_s     (dreq_s),
      .wr_en      (reg_we),
      .wr_addr    (reg_addr),
      .wr_data    (reg_wdata),
      .mem_req    (mem_req),
      .mem_we     (mem_we),
      .mem_addr   (mem_addr),
      .mem_nbytes (mem_nbytes),
      .mem_wdata  (mem_wdata),
      .mem_ack    (mem_ack),
      .mem_err    (mem_err),
      .mem_rdata  (mem_rdata),
      .stopped    (stopped),
      .clr_run    (clr_run),
      .set_end    (set_end),
      .set_start  (set_start),
      .set_err    (set_err),
      .link_q     (link_q),
      .src_q      (src_q),
      .tgt_q      (tgt_q),
      .cmd_word   (cmd_word)
   );

   always_comb begin
      case (reg_addr)
         RA_CSR:  reg_rdata = csr_value;
         RA_LINK: reg_rdata = link_q;
         RA_SRC:  reg_rdata = src_q;
         RA_TGT:  reg_rdata = tgt_q;
         RA_CMD:  reg_rdata = cmd_word;
         default: reg_rdata = '0;
      endcase
   end
endmodule

// File: rtl/chan_dma_chk.sv
module chan_dma_chk (
   input logic        clk,
   input logic        rst_n,
   input logic        mem_req,
   input logic        mem_ack,
   input logic        mem_we,
   input logic        mem_err,
   input logic [31:0] mem_addr,
   input logic [2:0]  mem_nbytes,
   input logic        irq,
   input logic        flag_end,
   input logic        flag_err,
   input logic        stopped,
   input logic [31:0] cmd_word
);
   AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we)); // R2
   AST_SIZE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req |-> (mem_nbytes != 3'd0) && (mem_nbytes <= 3'd4)); // R3
   AST_ERR_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req && mem_ack && mem_err |=> flag_err); // R8
   AST_ERR_HALTS: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req && mem_ack && mem_err |=> stopped); // R8
   AST_END_GATED: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(flag_end) |-> cmd_word[21]); // R6
   AST_ERR_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
      flag_err |-> irq); // R12
endmodule

bind chain_dma_chan chan_dma_chk i_chk (.*);

// File: tb/test_chain_dma_chan.sv
module test_chain_dma_chan;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_we = 1'b0;
   logic [2:0]  reg_addr = 3'd0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic        mem_req, mem_we;
   logic [31:0] mem_addr, mem_wdata;
   logic [2:0]  mem_nbytes;
   logic        mem_ack = 1'b0;
   logic        mem_err = 1'b0;
   logic [31:0] mem_rdata = '0;
   logic        dreq = 1'b0;
   logic        irq;

   int checks = 0;
   int errors = 0;
   logic [7:0] mem [0:4095];

   always #4 clk = ~clk;   // 125 MHz

   chain_dma_chan i_chain_dma_chan (
      .clk (clk), .rst_n (rst_n),
      .reg_we (reg_we), .reg_addr (reg_addr), .reg_wdata (reg_wdata), .reg_rdata (reg_rdata),
      .mem_req (mem_req), .mem_we (mem_we), .mem_addr (mem_addr), .mem_nbytes (mem_nbytes),
      .mem_wdata (mem_wdata), .mem_ack (mem_ack), .mem_err (mem_err), .mem_rdata (mem_rdata),
      .dreq (dreq), .irq (irq)
   );

   // memory model: one acknowledge per request, addresses with bit 31 set answer with an error
   always @(negedge clk) begin
      if (mem_req && !mem_ack) begin
         mem_ack <= 1'b1;
         mem_err <= mem_addr[31];
         if (!mem_addr[31]) begin
            if (mem_we) begin
               for (int i = 0; i < 4; i++)
                  if (i < int'(mem_nbytes)) mem[12'(mem_addr[11:0] + i)] = mem_wdata[8*i +: 8];
            end else begin
               mem_rdata <= {mem[12'(mem_addr[11:0] + 3)], mem[12'(mem_addr[11:0] + 2)],
                             mem[12'(mem_addr[11:0] + 1)], mem[mem_addr[11:0]]};
            end
         end
      end else begin
         mem_ack <= 1'b0;
         mem_err <= 1'b0;
      end
   end

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [2:0] a, input logic [31:0] d);
      @(negedge clk);
      reg_we = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_we = 1'b0;
   endtask

   task automatic rd(input logic [2:0] a, output logic [31:0] v);
      @(negedge clk);
      reg_addr = a;
      #1 v = reg_rdata;
   endtask

   task automatic put_word(input int a, input logic [31:0] v);
      for (int i = 0; i < 4; i++) mem[a + i] = v[8*i +: 8];
   endtask

   task automatic put_desc(input int a, input logic [31:0] lnk, input logic [31:0] s,
                           input logic [31:0] t, input logic [31:0] c);
      put_word(a, lnk); put_word(a + 4, s); put_word(a + 8, t); put_word(a + 12, c);
   endtask

   task automatic fill(input int a, input int n, input int seed);
      for (int i = 0; i < n; i++) mem[a + i] = 8'((seed + i * 7) & 8'hff);
   endtask

   task automatic wait_stop();
      logic [31:0] v;
      repeat (4) @(posedge clk);
      for (int i = 0; i < 5000; i++) begin
         rd(3'd0, v);
         if (v[3]) break;
      end
   endtask

   task automatic cmp_bytes(input string req, input int src, input int dst, input int n);
      for (int i = 0; i < n; i++) chk(req, {24'd0, mem[dst + i]}, {24'd0, mem[src + i]});
   endtask

   localparam logic [31:0] INC2 = 32'hC000_0000;

   task automatic t_reset();
      logic [31:0] v;
      rd(3'd0, v);
      chk("R1 csr after reset", v, 32'h0000_0008);
      chk("R1 irq after reset", {31'd0, irq}, 32'd0);
   endtask

   task automatic t_single();
      logic [31:0] v;
      fill(32'h100, 20, 3);
      put_desc(32'h400, 32'h1, 32'h100, 32'h200, INC2 | (3 << 16) | (3 << 14) | (1 << 21) | 20);
      wr(3'd1, 32'h400);
      wr(3'd0, 32'h8000_0000);
      wait_stop();
      cmp_bytes("R3 four-byte copy", 32'h100, 32'h200, 20);
      rd(3'd0, v); chk("R2 R6 csr after single descriptor", v, 32'h0000_000C);
      chk("R12 irq from end flag", {31'd0, irq}, 32'd1);
      rd(3'd2, v); chk("R4 source advanced", v, 32'h114);
      rd(3'd4, v); chk("R4 remaining zero", {19'd0, v[12:0]}, 32'd0);
      wr(3'd0, 32'h0);
      rd(3'd0, v); chk("R7 zero write keeps flags", v, 32'h0000_000C);
      wr(3'd0, 32'h7);
      rd(3'd0, v); chk("R7 flags cleared", v, 32'h0000_0008);
      chk("R12 irq low after clear", {31'd0, irq}, 32'd0);
   endtask

   task automatic t_chain();
      logic [31:0] v;
      fill(32'h140, 7, 11); fill(32'h160, 5, 40); fill(32'h180, 4, 90);
      put_desc(32'h410, 32'h420, 32'h140, 32'h240, INC2 | (1 << 16) | (2 << 14) | 7);
      put_desc(32'h420, 32'h441, 32'h160, 32'h260, INC2 | (1 << 21) | (1 << 14) | 5);
      put_desc(32'h440, 32'h1, 32'h180, 32'h2A0, INC2 | (1 << 14) | 4);
      wr(3'd1, 32'h410);
      wr(3'd0, 32'h8000_0000);
      wait_stop();
      cmp_bytes("R3 two-byte copy odd length", 32'h140, 32'h240, 7);
      cmp_bytes("R2 second linked descriptor", 32'h160, 32'h260, 5);
      for (int i = 0; i < 4; i++) chk("R2 halted on stop bit", {24'd0, mem[32'h2A0 + i]}, 32'd0);
      rd(3'd1, v); chk("R2 link register", v, 32'h441);
      rd(3'd0, v); chk("R6 end flag at chain end", v, 32'h0000_000C);
      wr(3'd0, 32'h7);
   endtask

   task automatic t_noinc();
      logic [31:0] v;
      fill(32'h1A0, 4, 21);
      put_desc(32'h450, 32'h1, 32'h1A0, 32'h2C0, 32'h8000_0000 | (1 << 22) | (1 << 16) | (1 << 14) | 4);
      wr(3'd1, 32'h450);
      wr(3'd0, 32'h8000_0000);
      wait_stop();
      chk("R4 fixed target holds last byte", {24'd0, mem[32'h2C0]}, {24'd0, mem[32'h1A3]});
      chk("R4 next target byte untouched", {24'd0, mem[32'h2C1]}, 32'd0);
      rd(3'd3, v); chk("R4 target address fixed", v, 32'h2C0);
      rd(3'd2, v); chk("R4 source address advanced", v, 32'h1A4);
      rd(3'd0, v); chk("R6 start flag without end flag", v, 32'h0000_000A);
      wr(3'd0, 32'h7);
   endtask

   task automatic t_zero_len();
      logic [31:0] v;
      put_desc(32'h460, 32'h1, 32'h1B0, 32'h2D0, INC2 | (1 << 21) | (3 << 14));
      mem[32'h1B0] = 8'h5A;
      wr(3'd1, 32'h460);
      wr(3'd0, 32'h8000_0000);
      wait_stop();
      chk("R3 zero length writes nothing", {24'd0, mem[32'h2D0]}, 32'd0);
      rd(3'd2, v); chk("R3 zero length source unchanged", v, 32'h1B0);
      rd(3'd0, v); chk("R6 zero length end flag", v, 32'h0000_000C);
      wr(3'd0, 32'h7);
   endtask

   task automatic t_flow();
      logic [31:0] v;
      fill(32'h1C0, 16, 55);
      put_desc(32'h470, 32'h1, 32'h1C0, 32'h2E0,
               INC2 | (1 << 29) | (1 << 21) | (1 << 16) | (3 << 14) | 16);
      wr(3'd1, 32'h470);
      wr(3'd0, 32'h8000_0000);
      repeat (40) @(posedge clk);
      rd(3'd0, v); chk("R5 stalled channel not stopped", {28'd0, v[3:0]}, 32'd0);
      chk("R5 request pending low", {31'd0, v[8]}, 32'd0);
      rd(3'd2, v); chk("R5 no progress without request", v, 32'h1C0);
      wr(3'd2, 32'h999);
      rd(3'd2, v); chk("R11 write while busy ignored", v, 32'h1C0);
      @(negedge clk) dreq = 1'b1;
      repeat (4) @(posedge clk);
      rd(3'd0, v); chk("R5 request pending visible", {31'd0, v[8]}, 32'd1);
      wait_stop();
      cmp_bytes("R5 paced copy", 32'h1C0, 32'h2E0, 16);
      @(negedge clk) dreq = 1'b0;
      wr(3'd0, 32'h7);
   endtask

   task automatic t_stop();
      logic [31:0] v;
      fill(32'h200 + 32'h100, 8, 77);
      put_desc(32'h490, 32'h1, 32'h300, 32'h320, INC2 | (1 << 28) | (1 << 16) | (3 << 14) | 8);
      wr(3'd1, 32'h490);
      wr(3'd0, 32'h8000_0000);
      repeat (20) @(posedge clk);
      wr(3'd0, 32'h0);
      repeat (5) @(posedge clk);
      rd(3'd0, v); chk("R9 cleared run stops channel", v, 32'h0000_0008);
      rd(3'd2, v); chk("R9 no data moved", v, 32'h300);
      chk("R9 target untouched", {24'd0, mem[32'h320]}, 32'd0);
      wr(3'd0, 32'h2000_0000);
      chk("R12 stop interrupt enable", {31'd0, irq}, 32'd1);
      wr(3'd0, 32'h0);
      chk("R12 stop interrupt disabled", {31'd0, irq}, 32'd0);
   endtask

   task automatic t_err();
      logic [31:0] v;
      wr(3'd1, 32'h8000_0000);
      wr(3'd0, 32'h8000_0000);
      wait_stop();
      rd(3'd0, v); chk("R8 bus error state", v, 32'h0000_0009);
      chk("R8 R12 irq on bus error", {31'd0, irq}, 32'd1);
      wr(3'd0, 32'h1);
      rd(3'd0, v); chk("R7 bus error cleared", v, 32'h0000_0008);
   endtask

   task automatic t_direct();
      logic [31:0] v;
      fill(32'h340, 8, 99);
      wr(3'd1, 32'h8000_0000);
      wr(3'd2, 32'h340);
      wr(3'd3, 32'h360);
      wr(3'd4, INC2 | (2 << 16) | (3 << 14) | (1 << 21) | 8);
      wr(3'd0, 32'hC000_0000);
      wait_stop();
      cmp_bytes("R10 direct copy", 32'h340, 32'h360, 8);
      rd(3'd0, v); chk("R10 no descriptor read, direct stays", v, 32'h4000_000C);
   endtask

   initial begin
      for (int i = 0; i < 4096; i++) mem[i] = 8'h00;
      repeat (3) @(posedge clk);
      @(negedge clk) rst_n = 1'b1;
      t_reset();
      t_single();
      t_chain();
      t_noinc();
      t_zero_len();
      t_flow();
      t_stop();
      t_err();
      t_direct();
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=%h expected=%h", 32'd1, 32'd0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule